// File: doc/BRIEF.md
# Transactional Footprint Conflict Tracker

This block follows a single processor's hardware transaction from begin to its end, and decides when that transaction has to fail. The core sends begin, commit and abort commands. A begin command carries the address of the failure handler. While a transaction is open, the block sees every local load and store by address and records the touched cache line in a set-associative tag array. Each way of the array holds a read mark and a write mark. The block also sees coherence requests from other agents. It compares them against the recorded footprint and aborts when a remote request and a local access to the same line disagree and at least one of them is a store.

There are five causes of failure. The core can abort on purpose. A remote request can conflict with the footprint. A new line can find its set already full. An asynchronous event can arrive (interrupt, exception, trap or context switch). A local access can be flagged as uncacheable. When the transaction fails, the block throws the whole footprint away in one cycle. It pulses an abort strobe with a 3-bit cause and presents the handler address that was latched at begin, so the core can redirect. A commit also clears the footprint and pulses a success strobe. The block holds only tags and marks. Data, register rollback and the coherence protocol live elsewhere.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a transaction, no transaction is open, all strobes are low, the cause output is 0, and any footprint recorded before the reset is gone.
- R2: A begin command (cmd_op 0) while idle opens a transaction one cycle later and latches cmd_handler. A begin command while a transaction is open is ignored, and the handler latched first is kept.
- R3: A commit command (cmd_op 1) while open pulses commit_done for one cycle, closes the transaction and empties the footprint, so later remote stores to those lines do not abort the next transaction.
- R4: A commit command while idle pulses commit_err for one cycle and has no other effect.
- R5: An abort command (cmd_op 2) while open pulses abort_valid with cause 1, and redirect_pc equals the latched handler.
- R6: A remote store that hits any marked line, or a remote read that hits a line with a write mark, aborts with cause 2.
- R7: A remote read of a line that carries only a read mark does not abort. A remote request to a line outside the footprint does not abort either.
- R8: With 8 ways, eight distinct lines in one set are accepted and touching one of them again allocates nothing. A ninth distinct line in that set aborts with cause 3.
- R9: async_evt while open aborts with cause 4.
- R10: A local access with acc_uncached set while open aborts with cause 5.
- R11: While idle, local accesses, remote requests, abort commands and async_evt have no effect, and idle accesses leave no marks.
- R12: When several abort causes occur in the same cycle, the reported cause follows this priority: asynchronous (4), conflict (2), uncacheable (3'd5), capacity (3), explicit (1). Any abort cause overrides a commit in that cycle.
- R13: The set index is taken from the address bits just above the line offset (bits 9:6 with 64-byte lines and 16 sets). Lines that differ in those bits never compete for ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the core |
| cmd_op | input | 2 | 0 begin, 1 commit, 2 abort, 3 none |
| cmd_handler | input | 32 | Failure-handler address, sampled with begin |
| acc_valid | input | 1 | Local access strobe |
| acc_write | input | 1 | Local access is a store |
| acc_uncached | input | 1 | Local access targets uncacheable space |
| acc_addr | input | 32 | Local access byte address |
| snp_valid | input | 1 | Remote coherence request strobe |
| snp_write | input | 1 | Remote request wants write ownership |
| snp_addr | input | 32 | Remote request byte address |
| async_evt | input | 1 | Interrupt, exception, trap or context switch |
| txn_active | output | 1 | A transaction is open |
| commit_done | output | 1 | One-cycle pulse: commit succeeded |
| commit_err | output | 1 | One-cycle pulse: commit issued while idle |
| abort_valid | output | 1 | One-cycle pulse: transaction aborted |
| abort_reason | output | 3 | Cause of the last abort |
| redirect_pc | output | 32 | Handler address latched at begin |

## Verification
The hardest situation to reach from the ports is a cycle in which several abort causes are true at once. One of them, capacity, only exists after exactly eight distinct lines have been loaded into one set. The directed part of the bench fills a chosen set way by way, touches a line that is already present to show that nothing new is allocated, and then offers a ninth line together with other causes in the same cycle. It repeats this, each time removing the cause of highest priority, so that every level of the priority order is seen on its own. A reset in the middle of a transaction followed by a remote store to a line that had been marked shows that the footprint did not survive the reset.

// File: rtl/txn_pkg.sv
// Shared encodings for the transactional conflict tracker.
// Assumes: cause codes are observed by the core and must stay fixed.
package txn_pkg;

    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_EXPLICIT = 3'd1,
        RSN_CONFLICT = 3'd2,
        RSN_CAPACITY = 3'd3,
        RSN_ASYNC    = 3'd4,
        RSN_UNCACHED = 3'd5
    } abort_rsn_e;

    typedef enum logic [1:0] {
        OP_BEGIN  = 2'd0,
        OP_COMMIT = 2'd1,
        OP_ABORT  = 2'd2,
        OP_NONE   = 2'd3
    } txn_op_e;

endpackage

// File: rtl/txn_set_lookup.sv
// Compares one tag against every way of a single set.
// Reports per-way hits, whether any hit way carries a read or write mark,
// whether the set is full, and a one-hot pick of the lowest free way.
// Assumes: at most one valid way holds a given tag.
module txn_set_lookup #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 22
) (
    input  logic [WAYS-1:0]             vld_i,
    input  logic [WAYS-1:0]             rd_i,
    input  logic [WAYS-1:0]             wr_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic [WAYS-1:0]             hit_o,
    output logic                        any_hit_o,
    output logic                        rd_hit_o,
    output logic                        wr_hit_o,
    output logic                        full_o,
    output logic [WAYS-1:0]             alloc_o
);

    // Per-way tag comparison, one comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_o[w] = vld_i[w] && (tags_i[w] == tag_i);
    end

    assign any_hit_o = |hit_o;
    assign rd_hit_o  = |(hit_o & rd_i);
    assign wr_hit_o  = |(hit_o & wr_i);
    assign full_o    = &vld_i;

    // Lowest-numbered free way is chosen for allocation.
    always_comb begin
        logic found;
        found   = 1'b0;
        alloc_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld_i[w] && !found) begin
                alloc_o[w] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/txn_tag_array.sv
// Tag array holding the transaction footprint: tag, valid, read mark and
// write mark per way. Looks up one local access and one remote request each
// cycle. Clear empties every set in one cycle and wins over marking.
// Assumes: mark_i is only raised when the access hits or a way is free.
module txn_tag_array #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 16,
    parameter int WAYS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              mark_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              snp_wr_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              acc_hit_o,
    output logic              acc_full_o,
    output logic              snp_conflict_o
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    logic [WAYS-1:0]            vld_q [SETS];
    logic [WAYS-1:0]            rd_q  [SETS];
    logic [WAYS-1:0]            wr_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];

    logic [SET_W-1:0] acc_set, snp_set;
    logic [TAG_W-1:0] acc_tag, snp_tag;

    assign acc_set = acc_addr_i[OFF_W +: SET_W];
    assign snp_set = snp_addr_i[OFF_W +: SET_W];
    assign acc_tag = acc_addr_i[ADDR_W-1 -: TAG_W];
    assign snp_tag = snp_addr_i[ADDR_W-1 -: TAG_W];

    logic [WAYS-1:0] acc_hit_v, acc_alloc, snp_hit_v, snp_alloc;
    logic            acc_rd_hit, acc_wr_hit, snp_any, snp_rd_hit, snp_wr_hit, snp_full;

    txn_set_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_acc_lookup (
        .vld_i    (vld_q[acc_set]),
        .rd_i     (rd_q[acc_set]),
        .wr_i     (wr_q[acc_set]),
        .tags_i   (tag_q[acc_set]),
        .tag_i    (acc_tag),
        .hit_o    (acc_hit_v),
        .any_hit_o(acc_hit_o),
        .rd_hit_o (acc_rd_hit),
        .wr_hit_o (acc_wr_hit),
        .full_o   (acc_full_o),
        .alloc_o  (acc_alloc)
    );

    txn_set_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_lookup (
        .vld_i    (vld_q[snp_set]),
        .rd_i     (rd_q[snp_set]),
        .wr_i     (wr_q[snp_set]),
        .tags_i   (tag_q[snp_set]),
        .tag_i    (snp_tag),
        .hit_o    (snp_hit_v),
        .any_hit_o(snp_any),
        .rd_hit_o (snp_rd_hit),
        .wr_hit_o (snp_wr_hit),
        .full_o   (snp_full),
        .alloc_o  (snp_alloc)
    );

    // A remote store collides with any mark; a remote read only with a write mark.
    assign snp_conflict_o = snp_wr_hit || (snp_wr_i && snp_any);

    // Footprint update: reset or clear empties all sets, else mark or allocate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rd_q[s]  <= '0;
                wr_q[s]  <= '0;
                tag_q[s] <= '0;
            end
        end else if (clr_i) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rd_q[s]  <= '0;
                wr_q[s]  <= '0;
            end
        end else if (mark_i) begin
            if (acc_hit_o) begin
                rd_q[acc_set] <= rd_q[acc_set] | (acc_hit_v & {WAYS{!acc_wr_i}});
                wr_q[acc_set] <= wr_q[acc_set] | (acc_hit_v & {WAYS{acc_wr_i}});
            end else begin
                vld_q[acc_set] <= vld_q[acc_set] | acc_alloc;
                rd_q[acc_set]  <= rd_q[acc_set] | (acc_alloc & {WAYS{!acc_wr_i}});
                wr_q[acc_set]  <= wr_q[acc_set] | (acc_alloc & {WAYS{acc_wr_i}});
                for (int w = 0; w < WAYS; w++) begin
                    if (acc_alloc[w]) tag_q[acc_set][w] <= acc_tag;
                end
            end
        end
    end

    // Summary of occupancy across the whole array, used by the checks below.
    logic any_valid;
    always_comb begin
        any_valid = 1'b0;
        for (int s = 0; s < SETS; s++) any_valid = any_valid | (|vld_q[s]);
    end

    // Clearing the footprint leaves no valid way behind.
    assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> !any_valid);

    // The controller never asks for allocation into a full set on a miss.
    assert_no_alloc_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mark_i && !acc_hit_o && acc_full_o));

    // Marking only happens on a recorded line or on a freshly allocated way.
    assert_alloc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_i && !acc_hit_o) |-> $onehot0(acc_alloc));

endmodule

// File: rtl/txn_ctrl.sv
// Transaction state control: opens and closes the transaction, latches the
// handler address, picks one abort cause by fixed priority, and issues the
// clear and mark requests to the tag array.
// Assumes: lookup results from the tag array are valid in the same cycle.
module txn_ctrl
    import txn_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [1:0]      cmd_op_i,
    input  logic [PC_W-1:0] cmd_handler_i,
    input  logic            acc_valid_i,
    input  logic            acc_uncached_i,
    input  logic            snp_valid_i,
    input  logic            async_evt_i,
    input  logic            acc_hit_i,
    input  logic            acc_full_i,
    input  logic            snp_conflict_i,
    output logic            clr_o,
    output logic            mark_o,
    output logic            active_o,
    output logic            commit_done_o,
    output logic            commit_err_o,
    output logic            abort_valid_o,
    output logic [2:0]      abort_reason_o,
    output logic [PC_W-1:0] redirect_pc_o
);

    logic            active_q, commit_q, err_q, abort_q;
    abort_rsn_e      reason_q;
    logic [PC_W-1:0] handler_q;

    logic       is_begin, is_commit, is_abort;
    logic       abort_now, commit_now;
    abort_rsn_e cause;

    assign is_begin  = cmd_valid_i && (cmd_op_i == OP_BEGIN);
    assign is_commit = cmd_valid_i && (cmd_op_i == OP_COMMIT);
    assign is_abort  = cmd_valid_i && (cmd_op_i == OP_ABORT);

    // Abort cause selection in fixed priority order while a transaction is open.
    always_comb begin
        cause = RSN_NONE;
        if (async_evt_i)                                 cause = RSN_ASYNC;
        else if (snp_valid_i && snp_conflict_i)          cause = RSN_CONFLICT;
        else if (acc_valid_i && acc_uncached_i)          cause = RSN_UNCACHED;
        else if (acc_valid_i && !acc_hit_i && acc_full_i) cause = RSN_CAPACITY;
        else if (is_abort)                               cause = RSN_EXPLICIT;
    end

    assign abort_now  = active_q && (cause != RSN_NONE);
    assign commit_now = active_q && is_commit && !abort_now;
    assign clr_o      = abort_now || commit_now;
    assign mark_o     = active_q && acc_valid_i && !acc_uncached_i && !abort_now;

    // Transaction state and handler latch; begin while open is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            handler_q <= '0;
        end else if (!active_q && is_begin) begin
            active_q  <= 1'b1;
            handler_q <= cmd_handler_i;
        end else if (clr_o) begin
            active_q  <= 1'b0;
        end
    end

    // Result strobes and the held abort cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            err_q    <= 1'b0;
            abort_q  <= 1'b0;
            reason_q <= RSN_NONE;
        end else begin
            commit_q <= commit_now;
            err_q    <= is_commit && !active_q;
            abort_q  <= abort_now;
            if (abort_now) reason_q <= cause;
        end
    end

    assign active_o       = active_q;
    assign commit_done_o  = commit_q;
    assign commit_err_o   = err_q;
    assign abort_valid_o  = abort_q;
    assign abort_reason_o = reason_q;
    assign redirect_pc_o  = handler_q;

    // An abort is only reported for a transaction that was open.
    assert_abort_needs_txn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid_o |-> ($past(active_q) && !active_q));

    // Success and failure never coincide.
    assert_result_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_done_o && abort_valid_o));

    // The handler does not move while a transaction stays open.
    assert_handler_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q)) |-> $stable(handler_q));

    // A commit error leaves the block idle.
    assert_err_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_err_o |-> (!active_q && !commit_done_o));

endmodule

// File: rtl/txn_conflict_tracker.sv
// Top of the transactional footprint conflict tracker. Joins the control
// block with the tag array and brings the result strobes to the ports.
// Assumes: all inputs are synchronous to clk; outputs are registered.
module txn_conflict_tracker #(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 16,
    parameter int WAYS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PC_W-1:0]   cmd_handler,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_uncached,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              async_evt,
    output logic              txn_active,
    output logic              commit_done,
    output logic              commit_err,
    output logic              abort_valid,
    output logic [2:0]        abort_reason,
    output logic [PC_W-1:0]   redirect_pc
);

    logic clr, mark, acc_hit, acc_full, snp_conflict;

    txn_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid_i   (cmd_valid),
        .cmd_op_i      (cmd_op),
        .cmd_handler_i (cmd_handler),
        .acc_valid_i   (acc_valid),
        .acc_uncached_i(acc_uncached),
        .snp_valid_i   (snp_valid),
        .async_evt_i   (async_evt),
        .acc_hit_i     (acc_hit),
        .acc_full_i    (acc_full),
        .snp_conflict_i(snp_conflict),
        .clr_o         (clr),
        .mark_o        (mark),
        .active_o      (txn_active),
        .commit_done_o (commit_done),
        .commit_err_o  (commit_err),
        .abort_valid_o (abort_valid),
        .abort_reason_o(abort_reason),
        .redirect_pc_o (redirect_pc)
    );

    txn_tag_array #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .SETS      (SETS),
        .WAYS      (WAYS)
    ) u_tags (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr_i         (clr),
        .mark_i        (mark),
        .acc_wr_i      (acc_write),
        .acc_addr_i    (acc_addr),
        .snp_wr_i      (snp_write),
        .snp_addr_i    (snp_addr),
        .acc_hit_o     (acc_hit),
        .acc_full_o    (acc_full),
        .snp_conflict_o(snp_conflict)
    );

    // A capacity abort must trace back to a cacheable local access.
    assert_capacity_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_valid && abort_reason == 3'd3) |-> $past(acc_valid && !acc_uncached));

    // A conflict abort must trace back to a remote request.
    assert_conflict_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_valid && abort_reason == 3'd2) |-> $past(snp_valid));

endmodule

// File: tb/txn_conflict_tracker_bench.sv
`timescale 1ns/1ps
module txn_conflict_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_op = 2'd3;
    logic [31:0] cmd_handler = 0;
    logic        acc_valid = 0, acc_write = 0, acc_uncached = 0;
    logic [31:0] acc_addr = 0;
    logic        snp_valid = 0, snp_write = 0;
    logic [31:0] snp_addr = 0;
    logic        async_evt = 0;
    logic        txn_active, commit_done, commit_err, abort_valid;
    logic [2:0]  abort_reason;
    logic [31:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    txn_conflict_tracker u_txn_conflict_tracker (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_handler(cmd_handler),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_uncached(acc_uncached),
        .acc_addr(acc_addr),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .async_evt(async_evt),
        .txn_active(txn_active), .commit_done(commit_done), .commit_err(commit_err),
        .abort_valid(abort_valid), .abort_reason(abort_reason), .redirect_pc(redirect_pc)
    );

    // Byte address of line (set s, tag t): 64-byte lines, set in bits 9:6.
    function automatic logic [31:0] ln(input int s, input int t);
        return (32'(t) << 10) | (32'(s) << 6);
    endfunction

    localparam logic [31:0] LA = 32'h0000_0440; // set 1 tag 1
    localparam logic [31:0] LB = 32'h0000_0840; // set 1 tag 2
    localparam logic [31:0] LC = 32'h0000_0480; // set 2 tag 1

    typedef struct packed {
        logic        cv; logic [1:0] op; logic [31:0] h;
        logic        av; logic aw; logic au; logic [31:0] aa;
        logic        sv; logic sw; logic [31:0] sa;
        logic        ev;
        logic        xa; logic xc; logic xe; logic xb; logic [2:0] xr;
        logic [31:0] xpc; logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{1,0,32'h1000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},  // R2 begin
        '{0,3,0, 1,0,0,LA,        0,0,0,  0, 1,0,0,0,0,0, 7},  // load A
        '{0,3,0, 0,0,0,0,         1,0,LA, 0, 1,0,0,0,0,0, 7},  // R7 remote read of read-marked
        '{0,3,0, 0,0,0,0,         1,1,LB, 0, 1,0,0,0,0,0, 7},  // R7 untouched line
        '{0,3,0, 1,1,0,LC,        0,0,0,  0, 1,0,0,0,0,0, 6},  // store C
        '{0,3,0, 0,0,0,0,         1,0,LC, 0, 0,0,0,1,2,32'h1000, 6}, // R6 read hits write mark
        '{1,0,32'h2000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},
        '{1,0,32'h3000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},  // R2 nested begin ignored
        '{1,2,0, 0,0,0,0,         0,0,0,  0, 0,0,0,1,1,32'h2000, 5}, // R5
        '{1,1,0, 0,0,0,0,         0,0,0,  0, 0,0,1,0,0,0, 4},  // R4
        '{0,3,0, 0,0,0,0,         0,0,0,  1, 0,0,0,0,0,0, 11}, // R11 idle event
        '{0,3,0, 1,1,0,LA,        1,1,LA, 0, 0,0,0,0,0,0, 11}, // R11 idle store/snoop
        '{1,0,32'h4000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},
        '{0,3,0, 0,0,0,0,         1,1,LA, 0, 1,0,0,0,0,0, 11}, // R11 idle store left no mark
        '{0,3,0, 1,0,0,LA,        0,0,0,  0, 1,0,0,0,0,0, 6},
        '{0,3,0, 0,0,0,0,         1,1,LA, 0, 0,0,0,1,2,32'h4000, 6}, // R6 store hits read mark
        '{1,0,32'h5000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},
        '{0,3,0, 0,0,0,0,         0,0,0,  1, 0,0,0,1,4,32'h5000, 9}, // R9
        '{1,0,32'h6000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},
        '{0,3,0, 1,0,1,LB,        0,0,0,  0, 0,0,0,1,5,32'h6000, 10}, // R10
        '{1,0,32'h7000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},
        '{0,3,0, 1,1,0,LA,        0,0,0,  0, 1,0,0,0,0,0, 3},
        '{1,1,0, 0,0,0,0,         0,0,0,  0, 0,1,0,0,0,0, 3},  // R3 commit
        '{1,0,32'h8000, 0,0,0,0,  0,0,0,  0, 1,0,0,0,0,0, 2},
        '{0,3,0, 0,0,0,0,         1,1,LA, 0, 1,0,0,0,0,0, 3},  // R3 footprint emptied
        '{1,1,0, 0,0,0,0,         0,0,0,  0, 0,1,0,0,0,0, 3}
    };

    task automatic drive(input logic cv, input logic [1:0] op, input logic [31:0] h,
                         input logic av, input logic aw, input logic au, input logic [31:0] aa,
                         input logic sv, input logic sw, input logic [31:0] sa, input logic ev);
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_handler = h;
        acc_valid = av; acc_write = aw; acc_uncached = au; acc_addr = aa;
        snp_valid = sv; snp_write = sw; snp_addr = sa; async_evt = ev;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_out(input int req, input logic xa, input logic xc, input logic xe,
                              input logic xb, input logic [2:0] xr, input logic [31:0] xpc);
        logic bad;
        checks++;
        bad = (txn_active !== xa) || (commit_done !== xc) || (commit_err !== xe) ||
              (abort_valid !== xb);
        if (xb) bad = bad || (abort_reason !== xr) || (redirect_pc !== xpc);
        if (bad) begin
            errors++;
            $display("FAIL R%0d: act=%b cmt=%b err=%b abt=%b rsn=%0d pc=%h exp act=%b cmt=%b err=%b abt=%b rsn=%0d pc=%h",
                     req, txn_active, commit_done, commit_err, abort_valid, abort_reason, redirect_pc,
                     xa, xc, xe, xb, xr, xpc);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state, including a cause output of 0.
        expect_out(1, 0, 0, 0, 0, 0, 0);
        checks++;
        if (abort_reason !== 3'd0) begin
            errors++;
            $display("FAIL R1: abort_reason=%0d expected 0", abort_reason);
        end
        @(negedge clk); rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].cv, VT[i].op, VT[i].h, VT[i].av, VT[i].aw, VT[i].au, VT[i].aa,
                  VT[i].sv, VT[i].sw, VT[i].sa, VT[i].ev);
            expect_out(int'(VT[i].req), VT[i].xa, VT[i].xc, VT[i].xe, VT[i].xb, VT[i].xr, VT[i].xpc);
        end

        // R8: fill set 3 with eight tags, retouch one, then a ninth aborts.
        drive(1, 2'd0, 32'h9000, 0,0,0,0, 0,0,0, 0);
        for (int t = 0; t < 8; t++) begin
            drive(0, 2'd3, 0, 1,0,0, ln(3, t), 0,0,0, 0);
            expect_out(8, 1, 0, 0, 0, 0, 0);
        end
        drive(0, 2'd3, 0, 1,1,0, ln(3, 5), 0,0,0, 0);
        expect_out(8, 1, 0, 0, 0, 0, 0);
        drive(0, 2'd3, 0, 1,0,0, ln(3, 8), 0,0,0, 0);
        expect_out(8, 0, 0, 0, 1, 3, 32'h9000);

        // R13: nine lines with one tag in nine different sets never overflow.
        drive(1, 2'd0, 32'hA000, 0,0,0,0, 0,0,0, 0);
        for (int s = 0; s < 9; s++) drive(0, 2'd3, 0, 1,0,0, ln(s, 7), 0,0,0, 0);
        expect_out(13, 1, 0, 0, 0, 0, 0);
        drive(1, 2'd1, 0, 0,0,0,0, 0,0,0, 0);
        expect_out(13, 0, 1, 0, 0, 0, 0);

        // R12: async outranks conflict, uncached and explicit abort.
        drive(1, 2'd0, 32'hB000, 0,0,0,0, 0,0,0, 0);
        drive(0, 2'd3, 0, 1,0,0, LA, 0,0,0, 0);
        drive(1, 2'd2, 0, 1,0,1, LB, 1,1,LA, 1);
        expect_out(12, 0, 0, 0, 1, 4, 32'hB000);
        // R12: conflict outranks uncached and explicit abort.
        drive(1, 2'd0, 32'hB100, 0,0,0,0, 0,0,0, 0);
        drive(0, 2'd3, 0, 1,0,0, LA, 0,0,0, 0);
        drive(1, 2'd2, 0, 1,0,1, LB, 1,1,LA, 0);
        expect_out(12, 0, 0, 0, 1, 2, 32'hB100);
        // R12: uncached outranks explicit abort.
        drive(1, 2'd0, 32'hB200, 0,0,0,0, 0,0,0, 0);
        drive(1, 2'd2, 0, 1,0,1, LB, 0,0,0, 0);
        expect_out(12, 0, 0, 0, 1, 5, 32'hB200);
        // R12: capacity outranks explicit abort.
        drive(1, 2'd0, 32'hB300, 0,0,0,0, 0,0,0, 0);
        for (int t = 0; t < 8; t++) drive(0, 2'd3, 0, 1,0,0, ln(5, t), 0,0,0, 0);
        drive(1, 2'd2, 0, 1,0,0, ln(5, 9), 0,0,0, 0);
        expect_out(12, 0, 0, 0, 1, 3, 32'hB300);
        // R12: an abort cause beats a commit in the same cycle.
        drive(1, 2'd0, 32'hB400, 0,0,0,0, 0,0,0, 0);
        drive(1, 2'd1, 0, 0,0,0,0, 0,0,0, 1);
        expect_out(12, 0, 0, 0, 1, 4, 32'hB400);

        // R1: reset in mid-transaction drops the transaction and its footprint.
        drive(1, 2'd0, 32'hC000, 0,0,0,0, 0,0,0, 0);
        drive(0, 2'd3, 0, 1,1,0, LC, 0,0,0, 0);
        @(negedge clk); rst_n = 1'b0;
        idle();
        expect_out(1, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        drive(1, 2'd0, 32'hC100, 0,0,0,0, 0,0,0, 0);
        drive(0, 2'd3, 0, 0,0,0,0, 1,0,LC, 0);
        expect_out(1, 1, 0, 0, 0, 0, 0);
        idle();
        expect_out(1, 1, 0, 0, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule